// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block walks a chain of transmit descriptors held in memory. A start pulse hands it the address of the first descriptor. For each descriptor it reads three header words: configuration, packet size and fragment count. It then reads one three-word record per fragment (address low, address high, byte count) and passes each fragment to a downstream data mover as a request. It waits for that request to finish before it reads the next record.

When every fragment of a packet has been handed over, the walker writes a status word back to the descriptor. Unless halting is requested, it then reads the link word that follows the last fragment record and moves to the next descriptor. Bit 0 of the link word marks the end of the chain. At the end of the walk the pending indication drops and a sticky done flag rises.

A per-packet configuration bit drives a programmable-interrupt flag. A non-zero loopback mode marks the packet's fragments for the loopback path and adds carrier-sense-lost to the written status. Memory is reached through a single 16-bit request/acknowledge master that uses byte addresses. In wide mode every descriptor word offset is doubled.

Top module: `twk_walker`

## Requirements
- R1: After reset, tx_pend, mem_req, frag_req, txdn_flag and pint_flag are all 0.
- R2: For each descriptor at pointer P, the walker first reads word offsets 1 (configuration), 2 (packet size) and 3 (fragment count), in that order. A word at offset k is at byte address P + 2k, or P + 4k when wide_mode was high at start. pkt_size shows the last size word read.
- R3: Fragment i (counting from 0) is read as three words at offsets 4+3i (address low), 5+3i (address high) and 6+3i (byte count). frag_req then rises with frag_addr = {high, low} and frag_len = count, and it holds these values until frag_done. The next record is not read until frag_done has been seen, and mem_req and frag_req are never high together.
- R4: A fragment count of 0 produces no fragment request. The status word is still written and the link is still followed.
- R5: After the fragments of a packet, one write goes to offset 0 with value 0x0001. When loop_mode is non-zero at the configuration read, the value is 0x0081 and frag_loop is 1 for that packet's fragments.
- R6: pint_flag takes bit 15 of each configuration word as it is read. It sets when that bit is 1 and clears when it is 0.
- R7: With halt_req low after the status write, the link word at offset 4+3*count is read. The low 16 bits of cur_desc become the link with bit 0 cleared, and the upper bits keep those of tx_base. The walk continues when link bit 0 is 0 and ends when it is 1.
- R8: With halt_req high when a packet's status write completes, no link word is read and the walk ends after that packet. cur_desc keeps its value.
- R9: When the walk ends, tx_pend falls and txdn_flag rises in the same cycle. txdn_flag stays 1 until the next accepted tx_go clears it.
- R10: A tx_go pulse while tx_pend is high is ignored, and the walk in progress is unaffected.
- R11: While mem_req is high and mem_ack is low, mem_req, mem_addr, mem_we and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_go | input | 1 | Start pulse for a walk |
| tx_base | input | 32 | Byte address of the first descriptor |
| wide_mode | input | 1 | Doubles descriptor word offsets, sampled at start |
| halt_req | input | 1 | Stop after the current packet instead of following the link |
| loop_mode | input | 2 | Non-zero routes packets to loopback |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 16 | Read data |
| frag_req | output | 1 | Fragment request to the data mover |
| frag_addr | output | 32 | Fragment start address |
| frag_len | output | 16 | Fragment byte count |
| frag_loop | output | 1 | Fragment belongs to a loopback packet |
| frag_done | input | 1 | Data mover finished the fragment |
| tx_pend | output | 1 | Walk in progress |
| txdn_flag | output | 1 | Sticky walk-done status |
| pint_flag | output | 1 | Programmable-interrupt status |
| cur_desc | output | 32 | Current descriptor pointer |
| pkt_size | output | 16 | Last packet size word read |

## Verification
Nearly every internal mistake here shows up as a wrong byte address on mem_addr. A wrong fragment index, a wrong latched wide mode or a wrong descriptor pointer all move the next request, and that request appears within about four cycles. The bench therefore logs every access and compares the log against a sequence it computes from the descriptor chain. A wrong fragment field shows on frag_addr or frag_len at the next request. A status or link mistake shows in the written status word, in cur_desc and in the flags once tx_pend falls.

// File: rtl/twk_pkg.sv
package twk_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_SIZE, S_CNT, S_FLO, S_FHI, S_FLEN, S_FRAG, S_STAT, S_LINK
  } twk_state_e;

  localparam logic [15:0] STAT_SENT = 16'h0001;
  localparam logic [15:0] STAT_CRSL = 16'h0080;
  localparam int CFG_PINT_BIT = 15;
  localparam int LINK_EOL_BIT = 0;
endpackage

// File: rtl/twk_offset.sv
module twk_offset #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  twk_pkg::twk_state_e state,
  input  logic [ADDR_W-1:0]   desc_ptr,
  input  logic                wide,
  input  logic [CNT_W-1:0]    frag_idx,
  input  logic [CNT_W-1:0]    frag_cnt,
  output logic [ADDR_W-1:0]   acc_addr
);
  import twk_pkg::*;
  localparam int OFF_W = CNT_W + 3;

  logic [OFF_W-1:0] idx3, cnt3, word_off;
  logic [OFF_W+1:0] byte_off;

  always_comb begin
    idx3 = (OFF_W'(frag_idx) << 1) + OFF_W'(frag_idx);
    cnt3 = (OFF_W'(frag_cnt) << 1) + OFF_W'(frag_cnt);
    case (state)
      S_CFG:   word_off = OFF_W'(1);
      S_SIZE:  word_off = OFF_W'(2);
      S_CNT:   word_off = OFF_W'(3);
      S_FLO:   word_off = idx3 + OFF_W'(4);
      S_FHI:   word_off = idx3 + OFF_W'(5);
      S_FLEN:  word_off = idx3 + OFF_W'(6);
      S_LINK:  word_off = cnt3 + OFF_W'(4);
      default: word_off = '0;
    endcase
    byte_off = wide ? {word_off, 2'b00} : {1'b0, word_off, 1'b0};
    acc_addr = desc_ptr + ADDR_W'(byte_off);
  end
endmodule

// File: rtl/twk_mem_port.sv
module twk_mem_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (mem_req && mem_ack) begin
        mem_req   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= mem_rdata;
      end else if (go && !mem_req) begin
        mem_req   <= 1'b1;
        mem_we    <= go_we;
        mem_addr  <= go_addr;
        mem_wdata <= go_wdata;
      end
    end
  end
endmodule

// File: rtl/twk_seq.sv
module twk_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tx_go,
  input  logic [ADDR_W-1:0]     tx_base,
  input  logic                  wide_mode,
  input  logic                  halt_req,
  input  logic [1:0]            loop_mode,
  input  logic                  rsp_valid,
  input  logic [DATA_W-1:0]     rsp_data,
  input  logic                  frag_done,
  output twk_pkg::twk_state_e   state,
  output logic [ADDR_W-1:0]     desc_ptr,
  output logic                  wide_q,
  output logic [CNT_W-1:0]      frag_idx,
  output logic [CNT_W-1:0]      frag_cnt,
  output logic                  go,
  output logic                  go_we,
  output logic [DATA_W-1:0]     go_wdata,
  output logic                  frag_req,
  output logic [2*DATA_W-1:0]   frag_addr,
  output logic [DATA_W-1:0]     frag_len,
  output logic                  frag_loop,
  output logic                  tx_pend,
  output logic                  txdn_flag,
  output logic                  pint_flag,
  output logic [DATA_W-1:0]     pkt_size
);
  import twk_pkg::*;

  logic              issued;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [CNT_W-1:0]  idx_nx;
  logic              is_access;

  always_comb begin
    case (state)
      S_CFG, S_SIZE, S_CNT, S_FLO, S_FHI, S_FLEN, S_STAT, S_LINK: is_access = 1'b1;
      default: is_access = 1'b0;
    endcase
    go       = is_access && !issued;
    go_we    = (state == S_STAT);
    go_wdata = STAT_SENT | (frag_loop ? STAT_CRSL : 16'h0000);
    idx_nx   = frag_idx + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      desc_ptr  <= '0;
      wide_q    <= 1'b0;
      frag_idx  <= '0;
      frag_cnt  <= '0;
      issued    <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
      frag_req  <= 1'b0;
      frag_addr <= '0;
      frag_len  <= '0;
      frag_loop <= 1'b0;
      tx_pend   <= 1'b0;
      txdn_flag <= 1'b0;
      pint_flag <= 1'b0;
      pkt_size  <= '0;
    end else begin
      if (go) issued <= 1'b1;
      if (rsp_valid) issued <= 1'b0;
      case (state)
        S_IDLE: if (tx_go) begin
          desc_ptr  <= tx_base;
          wide_q    <= wide_mode;
          tx_pend   <= 1'b1;
          txdn_flag <= 1'b0;
          state     <= S_CFG;
        end
        S_CFG: if (rsp_valid) begin
          pint_flag <= rsp_data[CFG_PINT_BIT];
          frag_loop <= |loop_mode;
          state     <= S_SIZE;
        end
        S_SIZE: if (rsp_valid) begin
          pkt_size <= rsp_data;
          state    <= S_CNT;
        end
        S_CNT: if (rsp_valid) begin
          frag_cnt <= CNT_W'(rsp_data);
          frag_idx <= '0;
          state    <= (rsp_data == '0) ? S_STAT : S_FLO;
        end
        S_FLO: if (rsp_valid) begin
          lo_q  <= rsp_data;
          state <= S_FHI;
        end
        S_FHI: if (rsp_valid) begin
          hi_q  <= rsp_data;
          state <= S_FLEN;
        end
        S_FLEN: if (rsp_valid) begin
          frag_addr <= {hi_q, lo_q};
          frag_len  <= rsp_data;
          frag_req  <= 1'b1;
          state     <= S_FRAG;
        end
        S_FRAG: if (frag_done) begin
          frag_req <= 1'b0;
          frag_idx <= idx_nx;
          state    <= (idx_nx == frag_cnt) ? S_STAT : S_FLO;
        end
        S_STAT: if (rsp_valid) begin
          if (halt_req) begin
            tx_pend   <= 1'b0;
            txdn_flag <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_LINK;
          end
        end
        S_LINK: if (rsp_valid) begin
          desc_ptr <= {desc_ptr[ADDR_W-1:DATA_W], rsp_data[DATA_W-1:1], 1'b0};
          if (rsp_data[LINK_EOL_BIT]) begin
            tx_pend   <= 1'b0;
            txdn_flag <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_CFG;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twk_walker.sv
module twk_walker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_go,
  input  logic [ADDR_W-1:0]   tx_base,
  input  logic                wide_mode,
  input  logic                halt_req,
  input  logic [1:0]          loop_mode,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                frag_req,
  output logic [2*DATA_W-1:0] frag_addr,
  output logic [DATA_W-1:0]   frag_len,
  output logic                frag_loop,
  input  logic                frag_done,
  output logic                tx_pend,
  output logic                txdn_flag,
  output logic                pint_flag,
  output logic [ADDR_W-1:0]   cur_desc,
  output logic [DATA_W-1:0]   pkt_size
);
  import twk_pkg::*;

  twk_state_e        state;
  logic [ADDR_W-1:0] desc_ptr, acc_addr;
  logic              wide_q, go, go_we, rsp_valid;
  logic [CNT_W-1:0]  frag_idx, frag_cnt;
  logic [DATA_W-1:0] go_wdata, rsp_data;

  assign cur_desc = desc_ptr;

  twk_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .tx_go(tx_go), .tx_base(tx_base),
    .wide_mode(wide_mode), .halt_req(halt_req), .loop_mode(loop_mode),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .frag_done(frag_done),
    .state(state), .desc_ptr(desc_ptr), .wide_q(wide_q),
    .frag_idx(frag_idx), .frag_cnt(frag_cnt),
    .go(go), .go_we(go_we), .go_wdata(go_wdata),
    .frag_req(frag_req), .frag_addr(frag_addr), .frag_len(frag_len),
    .frag_loop(frag_loop), .tx_pend(tx_pend), .txdn_flag(txdn_flag),
    .pint_flag(pint_flag), .pkt_size(pkt_size)
  );

  twk_offset #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_off (
    .state(state), .desc_ptr(desc_ptr), .wide(wide_q),
    .frag_idx(frag_idx), .frag_cnt(frag_cnt), .acc_addr(acc_addr)
  );

  twk_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .go(go), .go_we(go_we), .go_addr(acc_addr),
    .go_wdata(go_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/twk_checks.sv
module twk_checks #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                mem_req,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                mem_ack,
  input logic                frag_req,
  input logic [2*DATA_W-1:0] frag_addr,
  input logic [DATA_W-1:0]   frag_len,
  input logic                frag_done,
  input logic                tx_pend,
  input logic                txdn_flag
);
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r3_frag_hold: assert property (@(posedge clk) disable iff (rst)
    frag_req && !frag_done |=> frag_req && $stable(frag_addr) && $stable(frag_len));

  a_r3_one_side: assert property (@(posedge clk) disable iff (rst)
    !(frag_req && mem_req));

  a_r9_done_on_end: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_pend) |-> txdn_flag);

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !tx_pend |-> !mem_req && !frag_req);

  a_r5_status_value: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> (mem_wdata == 16'h0001 || mem_wdata == 16'h0081));
endmodule

bind twk_walker twk_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .frag_req(frag_req), .frag_addr(frag_addr), .frag_len(frag_len),
  .frag_done(frag_done), .tx_pend(tx_pend), .txdn_flag(txdn_flag)
);

// File: tb/sim_twk_walker.sv
`timescale 1ns/1ps
module sim_twk_walker;
  logic        clk = 1'b0, rst = 1'b1;
  logic        tx_go = 1'b0, wide_mode = 1'b0, halt_req = 1'b0;
  logic [31:0] tx_base = '0;
  logic [1:0]  loop_mode = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic        frag_req, frag_loop, frag_done = 1'b0;
  logic [31:0] frag_addr;
  logic [15:0] frag_len;
  logic        tx_pend, txdn_flag, pint_flag;
  logic [31:0] cur_desc;
  logic [15:0] pkt_size;

  always #4 clk = ~clk;

  twk_walker u0 (.*);

  logic [15:0] mem [0:8191];
  logic [31:0] act_addr [0:2047];
  logic        act_we   [0:2047];
  int          act_n;
  logic [31:0] exp_addr [0:2047];
  logic        exp_we   [0:2047];
  int          exp_n;
  logic [31:0] act_fa [0:511];
  logic [15:0] act_fl [0:511];
  logic        act_lp [0:511];
  int          act_fn;
  logic [31:0] exp_fa [0:511];
  logic [15:0] exp_fl [0:511];
  logic        exp_lp [0:511];
  int          exp_fn;
  int          mdly, fdly;
  int          nchk = 0, nfail = 0;

  logic [31:0] exp_cur, st_addr [0:7];
  logic        exp_pint;
  logic [15:0] exp_size, exp_st;
  int          n_st;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) mdly <= 0;
    else if (mem_req && !mem_ack) begin
      if (mdly == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[13:1]];
        if (mem_we) mem[mem_addr[13:1]] <= mem_wdata;
        if (act_n < 2048) begin
          act_addr[act_n] <= mem_addr;
          act_we[act_n]   <= mem_we;
        end
        act_n <= act_n + 1;
        mdly  <= $urandom_range(2, 0);
      end else mdly <= mdly - 1;
    end
  end

  always @(posedge clk) begin
    frag_done <= 1'b0;
    if (rst) fdly <= 0;
    else if (frag_req && !frag_done) begin
      if (fdly == 0) begin
        frag_done <= 1'b1;
        if (act_fn < 512) begin
          act_fa[act_fn] <= frag_addr;
          act_fl[act_fn] <= frag_len;
          act_lp[act_fn] <= frag_loop;
        end
        act_fn <= act_fn + 1;
        fdly   <= $urandom_range(3, 0);
      end else fdly <= fdly - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [15:0] v);
    mem[a[13:1]] = v;
  endtask

  task automatic expect_acc(input logic [31:0] a, input logic we);
    exp_addr[exp_n] = a;
    exp_we[exp_n]   = we;
    exp_n++;
  endtask

  // Builds a chain in memory and the access sequence the walk must produce.
  // cnt_fix < 0 picks random fragment counts 0..5.
  task automatic build(input logic [31:0] base, input int npk, input bit wide,
                       input bit halt, input bit lb, input int cnt_fix,
                       input int pint_mode);
    int m;
    m = wide ? 4 : 2;
    exp_n = 0; exp_fn = 0; n_st = 0;
    exp_st = lb ? 16'h0081 : 16'h0001;
    exp_cur = base;
    for (int k = 0; k < npk; k++) begin
      logic [31:0] p, nxt;
      logic [15:0] cfg, sz, lnk;
      int c;
      p   = base + 32'(k * 256);
      nxt = base + 32'((k + 1) * 256);
      c   = (cnt_fix >= 0) ? cnt_fix : $urandom_range(5, 0);
      cfg = 16'($urandom());
      if (pint_mode == 1) cfg[15] = (k == 0);
      sz  = 16'($urandom());
      lnk = {nxt[15:1], (k == npk - 1)};
      put(p, 16'hDEAD);
      put(p + 32'(1 * m), cfg);
      put(p + 32'(2 * m), sz);
      put(p + 32'(3 * m), 16'(c));
      for (int i = 0; i < c; i++) begin
        logic [31:0] fa;
        logic [15:0] fl;
        fa = $urandom();
        fl = 16'($urandom());
        put(p + 32'((4 + 3 * i) * m), fa[15:0]);
        put(p + 32'((5 + 3 * i) * m), fa[31:16]);
        put(p + 32'((6 + 3 * i) * m), fl);
      end
      put(p + 32'((4 + 3 * c) * m), lnk);
      if (!(halt && k > 0)) begin
        expect_acc(p + 32'(m), 1'b0);
        expect_acc(p + 32'(2 * m), 1'b0);
        expect_acc(p + 32'(3 * m), 1'b0);
        for (int i = 0; i < c; i++) begin
          expect_acc(p + 32'((4 + 3 * i) * m), 1'b0);
          expect_acc(p + 32'((5 + 3 * i) * m), 1'b0);
          expect_acc(p + 32'((6 + 3 * i) * m), 1'b0);
          exp_fa[exp_fn] = {mem[(p + 32'((5 + 3 * i) * m)) >> 1 & 32'h1FFF],
                            mem[(p + 32'((4 + 3 * i) * m)) >> 1 & 32'h1FFF]};
          exp_fl[exp_fn] = mem[(p + 32'((6 + 3 * i) * m)) >> 1 & 32'h1FFF];
          exp_lp[exp_fn] = lb;
          exp_fn++;
        end
        expect_acc(p, 1'b1);
        st_addr[n_st] = p; n_st++;
        exp_pint = cfg[15];
        exp_size = sz;
        if (!halt) begin
          expect_acc(p + 32'((4 + 3 * c) * m), 1'b0);
          exp_cur = {base[31:16], lnk[15:1], 1'b0};
        end
      end
    end
  endtask

  task automatic run(input logic [31:0] base, input bit wide, input bit halt,
                     input logic [1:0] lm, input bit poke, input string tag);
    int t;
    bit ok;
    int bad;
    act_n = 0; act_fn = 0;
    @(negedge clk);
    tx_base = base; wide_mode = wide; halt_req = halt; loop_mode = lm; tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
    chk(tx_pend === 1'b1 && txdn_flag === 1'b0, "R9", {tag, " start clears done"},
        {30'b0, tx_pend, txdn_flag}, 32'h2);
    if (poke) begin
      repeat (10) @(negedge clk);
      tx_base = base ^ 32'h0000_0800; wide_mode = ~wide; tx_go = 1'b1;
      @(negedge clk);
      tx_go = 1'b0;
    end
    t = 0;
    while (tx_pend === 1'b1 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, "R9", {tag, " walk ends"}, 32'(t), 32'd20000);
    chk(txdn_flag === 1'b1, "R9", {tag, " done flag"}, {31'b0, txdn_flag}, 32'h1);
    ok = (act_n == exp_n); bad = -1;
    for (int i = 0; i < exp_n && i < act_n; i++)
      if (bad < 0 && (act_addr[i] !== exp_addr[i] || act_we[i] !== exp_we[i])) bad = i;
    if (bad >= 0) ok = 0;
    chk(ok, poke ? "R10" : (halt ? "R8" : "R2 R7"), {tag, " access sequence"},
        bad >= 0 ? act_addr[bad] : 32'(act_n), bad >= 0 ? exp_addr[bad] : 32'(exp_n));
    ok = (act_fn == exp_fn); bad = -1;
    for (int i = 0; i < exp_fn && i < act_fn; i++)
      if (bad < 0 && (act_fa[i] !== exp_fa[i] || act_fl[i] !== exp_fl[i] || act_lp[i] !== exp_lp[i])) bad = i;
    if (bad >= 0) ok = 0;
    chk(ok, "R3 R4", {tag, " fragment requests"},
        bad >= 0 ? act_fa[bad] : 32'(act_fn), bad >= 0 ? exp_fa[bad] : 32'(exp_fn));
    for (int i = 0; i < n_st; i++)
      chk(mem[st_addr[i][13:1]] === exp_st, "R5", {tag, " status word"},
          {16'b0, mem[st_addr[i][13:1]]}, {16'b0, exp_st});
    chk(cur_desc === exp_cur, halt ? "R8" : "R7", {tag, " cur_desc"}, cur_desc, exp_cur);
    chk(pint_flag === exp_pint, "R6", {tag, " pint_flag"}, {31'b0, pint_flag}, {31'b0, exp_pint});
    chk(pkt_size === exp_size, "R2", {tag, " pkt_size"}, {16'b0, pkt_size}, {16'b0, exp_size});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    act_n = 0; act_fn = 0;
    for (int i = 0; i < 8192; i++) mem[i] = 16'($urandom());
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_pend === 0 && mem_req === 0 && frag_req === 0 && txdn_flag === 0 && pint_flag === 0,
        "R1", "reset state", {27'b0, tx_pend, mem_req, frag_req, txdn_flag, pint_flag}, 32'h0);

    build(32'h00A5_0400, 3, 1'b0, 1'b0, 1'b0, 2, 0);
    run(32'h00A5_0400, 1'b0, 1'b0, 2'b00, 1'b0, "narrow");
    build(32'h1234_0400, 2, 1'b1, 1'b0, 1'b1, 3, 0);
    run(32'h1234_0400, 1'b1, 1'b0, 2'b10, 1'b0, "wide loop");
    build(32'h0000_0600, 2, 1'b0, 1'b0, 1'b0, 0, 0);
    run(32'h0000_0600, 1'b0, 1'b0, 2'b00, 1'b0, "R4 zero count");
    build(32'h0007_0400, 3, 1'b0, 1'b1, 1'b0, 2, 0);
    run(32'h0007_0400, 1'b0, 1'b1, 2'b00, 1'b0, "R8 halt");
    build(32'h0000_0800, 2, 1'b0, 1'b0, 1'b0, 1, 1);
    run(32'h0000_0800, 1'b0, 1'b0, 2'b00, 1'b0, "R6 pint clears");
    build(32'h0000_0400, 2, 1'b0, 1'b0, 1'b1, 2, 0);
    run(32'h0000_0400, 1'b0, 1'b0, 2'b01, 1'b1, "R10 busy go");
    for (int r = 0; r < 8; r++) begin
      bit w, h;
      logic [1:0] lm;
      logic [31:0] b;
      w  = 1'($urandom());
      h  = ($urandom_range(3, 0) == 0);
      lm = 2'($urandom());
      b  = {16'($urandom()), 16'h0400};
      build(b, $urandom_range(4, 1), w, h, |lm, -1, 0);
      run(b, w, h, lm, 1'b0, "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule